// File: doc/BRIEF.md
# Privileged Special-Register Access Gate

This block sits beside the execute stage of a 32-bit core and serves the two special-register move operations: move-from (read) and move-to (write). Each request carries an address, write data and a read/write select. The block checks three things in turn: whether the request is privileged, whether the address is inside the implemented range, and whether the addressed register allows that direction of access. It then reads or updates a small special-register file. It also produces the side effects tied to a few addresses: a forced status bit on a status write, a program-counter redirect on a next-PC write, and a timer mode register that only accepts zero.

A request is privileged when the supervisor bit `sm` is set, or when the user-access bit `sumra` is set. Every request gets one response, one cycle after it is sampled. A read raises `rd_valid` with registered data. A refused or invalid access raises `warn` for one cycle. A next-PC write raises `redirect_valid` with the target in `redirect_pc`, and the core uses that pulse both to jump and to drop any pending delay-slot state.

The controller is a response state machine with six states:
- IDLE: no request was seen.
- RD_DONE: a granted read.
- RD_FAULT: a refused or invalid read.
- WR_DONE: a write that was stored, or a zero write to the timer mode register.
- WR_FAULT: a refused, invalid or rejected write.
- REDIRECT: a next-PC write.

Each cycle the state register is loaded from the request sampled at that edge. With no request the next state is IDLE. For a read, the next state is RD_DONE if the read is granted and RD_FAULT otherwise. For a write, the next state is WR_DONE, WR_FAULT or REDIRECT, following the rules above. All outputs are decoded from the current state.

Address map (in a `ADDR_W`-bit address space):

| Address | Register | Read | Write |
|---|---|---|---|
| 0x00 | version constant | yes | no |
| 0x01 | unit-present constant | yes | no |
| 0x02 | CPU configuration constant | yes | no |
| 0x10 | next PC | no | redirect |
| 0x11 | status | yes | stored, with bit `FO_BIT` forced to 1 |
| 0x12 | previous PC (the `prev_pc` input) | yes | no |
| 0x14 | FP control/status | yes | yes |
| 0x20 | exception PC | yes | yes |
| 0x30 | exception status | no | yes |
| 0x38 | timer mode | no | zero only |
| 0x3A | MAC low | yes | yes |
| 0x3B | MAC high | yes | yes |
| `SHADOW_BASE` to `SHADOW_BASE+SHADOW_N-1` | shadow GPRs | yes | yes |

Top module: `spr_gate`

## Requirements
- R1: When `sm` and `sumra` are both 0, a read returns 0 with `warn`, and a write changes no register, raises `warn` and gives no redirect. With either bit set, reads and writes are served.
- R2: Any address at or above `NUM_SPR` is invalid. A read there returns 0 with `warn`, and a write there raises `warn` and stores nothing.
- R3: A privileged read returns the stored value for every readable entry of the address map. For exception status, next PC, timer mode and any unmapped address below `NUM_SPR`, a read returns 0 with `warn`.
- R4: A privileged write to FP control, exception PC, exception status, MAC low, MAC high or a shadow GPR stores the full 32-bit value, with no `warn` and no redirect.
- R5: A privileged write to status stores the value with bit `FO_BIT` forced to 1, without `warn`. Status resets to `SR_RESET`.
- R6: A privileged write to next PC stores nothing. One cycle later it raises `redirect_valid` for one cycle, with `redirect_pc` equal to the written value, and no `warn`.
- R7: A privileged write of zero to timer mode is accepted without `warn`. A nonzero value raises `warn` and is not stored.
- R8: `rd_valid`, `warn` and `redirect_valid` are each a one-cycle response in the cycle after a request, and all are 0 after reset and after a cycle with no request. `rd_valid` and `redirect_valid` are never high together.
- R9: Shadow GPRs are addressed as `SHADOW_BASE + index`, and each index holds its own value. The previous-PC register reads the `prev_pc` input as it was in the request cycle. The three constants read as `VERSION_VAL`, `UNITS_VAL` and `CONFIG_VAL`.
- R10: A privileged write to a read-only entry (the three constants, previous PC) or to an unmapped address raises `warn` and leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_addr | input | ADDR_W | Special-register address |
| req_wdata | input | 32 | Write data |
| sm | input | 1 | Supervisor mode bit |
| sumra | input | 1 | User-mode access permission bit |
| prev_pc | input | 32 | Previous-PC value presented for reads |
| rd_valid | output | 1 | Read response valid (one cycle) |
| rd_data | output | 32 | Read data, 0 on a faulted read |
| warn | output | 1 | Refused or invalid access (one cycle) |
| redirect_valid | output | 1 | Jump to redirect_pc and clear pending delay slot |
| redirect_pc | output | 32 | Redirect target |

## Verification
Some properties are checked by assertions on every cycle:
- a faulted read returns zero;
- a response appears only after a request of the matching direction;
- an unprivileged request never redirects and always warns;
- the forced status bit is set after every status write;
- a stored FP-control write holds the written value;
- a nonzero timer-mode write warns.

Other properties can only be shown by the bench's scenarios. The bench sweeps every address in the small configuration, writing and then reading under each privilege combination. This shows the asymmetry between the read and write maps and that refused writes leave every register unchanged. It also shows that each shadow index is stored separately.

// File: rtl/spr_gate_pkg.sv
`timescale 1ns/1ps
package spr_gate_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DONE,
        ST_RD_FAULT,
        ST_WR_DONE,
        ST_WR_FAULT,
        ST_REDIRECT
    } gate_state_t;

    typedef enum logic [3:0] {
        K_VERSION,
        K_UNITS,
        K_CONFIG,
        K_STATUS,
        K_PREVPC,
        K_FPCTL,
        K_EPC,
        K_ESTAT,
        K_MACLO,
        K_MACHI,
        K_NEXTPC,
        K_TMODE,
        K_SHADOW,
        K_NONE
    } spr_kind_t;

    localparam logic [31:0] A_VERSION = 32'h00;
    localparam logic [31:0] A_UNITS   = 32'h01;
    localparam logic [31:0] A_CONFIG  = 32'h02;
    localparam logic [31:0] A_NEXTPC  = 32'h10;
    localparam logic [31:0] A_STATUS  = 32'h11;
    localparam logic [31:0] A_PREVPC  = 32'h12;
    localparam logic [31:0] A_FPCTL   = 32'h14;
    localparam logic [31:0] A_EPC     = 32'h20;
    localparam logic [31:0] A_ESTAT   = 32'h30;
    localparam logic [31:0] A_TMODE   = 32'h38;
    localparam logic [31:0] A_MACLO   = 32'h3A;
    localparam logic [31:0] A_MACHI   = 32'h3B;

    function automatic logic kind_readable(spr_kind_t k);
        unique case (k)
            K_VERSION, K_UNITS, K_CONFIG, K_STATUS, K_PREVPC,
            K_FPCTL, K_EPC, K_MACLO, K_MACHI, K_SHADOW: return 1'b1;
            default:                                    return 1'b0;
        endcase
    endfunction

    function automatic logic kind_storable(spr_kind_t k);
        unique case (k)
            K_FPCTL, K_EPC, K_ESTAT, K_MACLO, K_MACHI,
            K_SHADOW, K_STATUS: return 1'b1;
            default:            return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/spr_gate_decode.sv
`timescale 1ns/1ps
module spr_gate_decode
    import spr_gate_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned NUM_SPR     = 32'h600,
    parameter int unsigned SHADOW_BASE = 32'h400,
    parameter int unsigned SHADOW_N    = 512,
    localparam int unsigned IDX_W      = (SHADOW_N > 1) ? $clog2(SHADOW_N) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output spr_kind_t         kind,
    output logic [IDX_W-1:0]  shadow_idx
);

    logic [31:0] a_ext;

    always_comb begin
        a_ext      = 32'(addr);
        kind       = K_NONE;
        shadow_idx = '0;
        if (a_ext < NUM_SPR) begin
            unique case (a_ext)
                A_VERSION: kind = K_VERSION;
                A_UNITS:   kind = K_UNITS;
                A_CONFIG:  kind = K_CONFIG;
                A_NEXTPC:  kind = K_NEXTPC;
                A_STATUS:  kind = K_STATUS;
                A_PREVPC:  kind = K_PREVPC;
                A_FPCTL:   kind = K_FPCTL;
                A_EPC:     kind = K_EPC;
                A_ESTAT:   kind = K_ESTAT;
                A_TMODE:   kind = K_TMODE;
                A_MACLO:   kind = K_MACLO;
                A_MACHI:   kind = K_MACHI;
                default: begin
                    if (a_ext >= SHADOW_BASE && a_ext < SHADOW_BASE + SHADOW_N) begin
                        kind       = K_SHADOW;
                        shadow_idx = IDX_W'(a_ext - SHADOW_BASE);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/spr_gate_regfile.sv
`timescale 1ns/1ps
module spr_gate_regfile
    import spr_gate_pkg::*;
#(
    parameter int unsigned SHADOW_N    = 512,
    parameter int unsigned FO_BIT      = 15,
    parameter logic [31:0] SR_RESET    = 32'h0000_8001,
    parameter logic [31:0] VERSION_VAL = 32'h1234_0001,
    parameter logic [31:0] UNITS_VAL   = 32'h0000_00F5,
    parameter logic [31:0] CONFIG_VAL  = 32'h0000_0020,
    localparam int unsigned IDX_W      = (SHADOW_N > 1) ? $clog2(SHADOW_N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  spr_kind_t        kind,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata,
    input  logic [31:0]      prev_pc,
    output logic [31:0]      rdata
);

    logic [31:0] sr_q, fpctl_q, epc_q, estat_q, maclo_q, machi_q;
    logic [31:0] shadow_rd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q    <= SR_RESET;
            fpctl_q <= '0;
            epc_q   <= '0;
            estat_q <= '0;
            maclo_q <= '0;
            machi_q <= '0;
        end else if (we) begin
            unique case (kind)
                K_STATUS: begin
                    sr_q         <= wdata;
                    sr_q[FO_BIT] <= 1'b1;
                end
                K_FPCTL: fpctl_q <= wdata;
                K_EPC:   epc_q   <= wdata;
                K_ESTAT: estat_q <= wdata;
                K_MACLO: maclo_q <= wdata;
                K_MACHI: machi_q <= wdata;
                default: ;
            endcase
        end
    end

    generate
        if (SHADOW_N > 0) begin : g_shadow
            logic [31:0] shadow_q [SHADOW_N];
            always_ff @(posedge clk) begin
                if (rst_n && we && kind == K_SHADOW) begin
                    shadow_q[idx] <= wdata;
                end
            end
            assign shadow_rd = shadow_q[idx];
        end else begin : g_no_shadow
            assign shadow_rd = '0;
        end
    endgenerate

    always_comb begin
        unique case (kind)
            K_VERSION: rdata = VERSION_VAL;
            K_UNITS:   rdata = UNITS_VAL;
            K_CONFIG:  rdata = CONFIG_VAL;
            K_STATUS:  rdata = sr_q;
            K_PREVPC:  rdata = prev_pc;
            K_FPCTL:   rdata = fpctl_q;
            K_EPC:     rdata = epc_q;
            K_ESTAT:   rdata = estat_q;
            K_MACLO:   rdata = maclo_q;
            K_MACHI:   rdata = machi_q;
            K_SHADOW:  rdata = shadow_rd;
            default:   rdata = '0;
        endcase
    end

    // R5: every status write leaves the forced bit set
    a_r5_fo_forced: assert property (@(posedge clk) disable iff (!rst_n)
        $past(we && kind == K_STATUS) |-> sr_q[FO_BIT]);

    // R4: a stored FP-control write holds the written word
    a_r4_fpctl_stored: assert property (@(posedge clk) disable iff (!rst_n)
        $past(we && kind == K_FPCTL) |-> fpctl_q == $past(wdata));

endmodule

// File: rtl/spr_gate_fsm.sv
`timescale 1ns/1ps
module spr_gate_fsm
    import spr_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        priv,
    input  spr_kind_t   kind,
    input  logic [31:0] wdata,
    output logic        store_en,
    output logic        rd_grant,
    output logic        redirect_grant,
    output logic        rd_valid,
    output logic        warn,
    output logic        redirect_valid
);

    gate_state_t state_q, state_d;

    always_comb begin
        state_d = ST_IDLE;
        if (req_valid) begin
            if (!req_write) begin
                state_d = (priv && kind_readable(kind)) ? ST_RD_DONE : ST_RD_FAULT;
            end else if (!priv) begin
                state_d = ST_WR_FAULT;
            end else begin
                unique case (kind)
                    K_NEXTPC: state_d = ST_REDIRECT;
                    K_TMODE:  state_d = (wdata == '0) ? ST_WR_DONE : ST_WR_FAULT;
                    default:  state_d = kind_storable(kind) ? ST_WR_DONE : ST_WR_FAULT;
                endcase
            end
        end
    end

    assign store_en       = req_valid && req_write && priv && kind_storable(kind);
    assign rd_grant       = (state_d == ST_RD_DONE);
    assign redirect_grant = (state_d == ST_REDIRECT);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        rd_valid       = 1'b0;
        warn           = 1'b0;
        redirect_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_RD_DONE:  rd_valid = 1'b1;
            ST_RD_FAULT: begin rd_valid = 1'b1; warn = 1'b1; end
            ST_WR_DONE:  ;
            ST_WR_FAULT: warn = 1'b1;
            ST_REDIRECT: redirect_valid = 1'b1;
            default:     ;
        endcase
    end

    // R7: a nonzero timer-mode write is rejected with a warning
    a_r7_tmode_nonzero_warns: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && priv && kind == K_TMODE && wdata != '0)
        |=> (warn && !redirect_valid));

    // R8: no response without a request in the previous cycle
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rd_valid && !warn && !redirect_valid));

endmodule

// File: rtl/spr_gate.sv
`timescale 1ns/1ps
module spr_gate
    import spr_gate_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned NUM_SPR     = 32'h600,
    parameter int unsigned SHADOW_BASE = 32'h400,
    parameter int unsigned SHADOW_N    = 512,
    parameter int unsigned FO_BIT      = 15,
    parameter logic [31:0] SR_RESET    = 32'h0000_8001,
    parameter logic [31:0] VERSION_VAL = 32'h1234_0001,
    parameter logic [31:0] UNITS_VAL   = 32'h0000_00F5,
    parameter logic [31:0] CONFIG_VAL  = 32'h0000_0020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              sm,
    input  logic              sumra,
    input  logic [31:0]       prev_pc,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              warn,
    output logic              redirect_valid,
    output logic [31:0]       redirect_pc
);

    localparam int unsigned IDX_W = (SHADOW_N > 1) ? $clog2(SHADOW_N) : 1;

    spr_kind_t        kind;
    logic [IDX_W-1:0] shadow_idx;
    logic [31:0]      rf_rdata;
    logic             priv, store_en, rd_grant, redirect_grant;
    logic [31:0]      rd_data_q, redirect_pc_q;

    assign priv = sm || sumra;

    spr_gate_decode #(
        .ADDR_W(ADDR_W), .NUM_SPR(NUM_SPR),
        .SHADOW_BASE(SHADOW_BASE), .SHADOW_N(SHADOW_N)
    ) i_decode (
        .addr(req_addr), .kind(kind), .shadow_idx(shadow_idx)
    );

    spr_gate_regfile #(
        .SHADOW_N(SHADOW_N), .FO_BIT(FO_BIT), .SR_RESET(SR_RESET),
        .VERSION_VAL(VERSION_VAL), .UNITS_VAL(UNITS_VAL), .CONFIG_VAL(CONFIG_VAL)
    ) i_regfile (
        .clk(clk), .rst_n(rst_n), .we(store_en), .kind(kind),
        .idx(shadow_idx), .wdata(req_wdata), .prev_pc(prev_pc), .rdata(rf_rdata)
    );

    spr_gate_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .priv(priv), .kind(kind), .wdata(req_wdata),
        .store_en(store_en), .rd_grant(rd_grant), .redirect_grant(redirect_grant),
        .rd_valid(rd_valid), .warn(warn), .redirect_valid(redirect_valid)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q     <= '0;
            redirect_pc_q <= '0;
        end else begin
            rd_data_q <= rd_grant ? rf_rdata : '0;
            if (redirect_grant) redirect_pc_q <= req_wdata;
        end
    end

    assign rd_data     = rd_data_q;
    assign redirect_pc = redirect_pc_q;

    // R2: a faulted read (refused, out of range or unreadable) returns zero
    a_r2_fault_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && warn) |-> rd_data == '0);

    // R1: an unprivileged request never redirects and always warns
    a_r1_unpriv_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !sm && !sumra) |=> (warn && !redirect_valid));

    // R8: a read response follows a read request
    a_r8_rd_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write));

    // R6: a redirect follows a privileged write
    a_r6_redirect_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> $past(req_valid && req_write && (sm || sumra)));

    // R8: read and redirect responses are exclusive
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && redirect_valid));

endmodule

// File: tb/test_spr_gate.sv
`timescale 1ns/1ps
module test_spr_gate;

    localparam int unsigned AW   = 8;
    localparam int unsigned NSPR = 32'h60;
    localparam int unsigned SB   = 32'h40;
    localparam int unsigned SN   = 16;
    localparam logic [31:0] VERV = 32'h1234_0001;
    localparam logic [31:0] UNV  = 32'h0000_00F5;
    localparam logic [31:0] CFGV = 32'h0000_0020;
    localparam logic [31:0] SRR  = 32'h0000_8001;
    localparam logic [31:0] FOM  = 32'h0000_8000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, sm = 1'b0, sumra = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0, prev_pc = '0;
    logic rd_valid, warn, redirect_valid;
    logic [31:0] rd_data, redirect_pc;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] mdl [0:255];

    always #2.5 clk = ~clk;

    spr_gate #(
        .ADDR_W(AW), .NUM_SPR(NSPR), .SHADOW_BASE(SB), .SHADOW_N(SN),
        .FO_BIT(15), .SR_RESET(SRR),
        .VERSION_VAL(VERV), .UNITS_VAL(UNV), .CONFIG_VAL(CFGV)
    ) i_spr_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .sm(sm), .sumra(sumra),
        .prev_pc(prev_pc), .rd_valid(rd_valid), .rd_data(rd_data), .warn(warn),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    function automatic bit plain_w(int a);
        return a == 'h14 || a == 'h20 || a == 'h30 || a == 'h3A || a == 'h3B ||
               (a >= SB && a < SB + SN);
    endfunction

    function automatic bit readable(int a);
        return a == 'h00 || a == 'h01 || a == 'h02 || a == 'h11 || a == 'h12 ||
               a == 'h14 || a == 'h20 || a == 'h3A || a == 'h3B ||
               (a >= SB && a < SB + SN);
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_wr(int a, logic [31:0] d);
        bit p = sm || sumra;
        bit ew = 1'b1;
        bit er = 1'b0;
        string rq = p ? ((a >= NSPR) ? "R2" : "R10") : "R1";
        if (p && a < NSPR) begin
            if (plain_w(a)) begin mdl[a] = d; ew = 1'b0; rq = "R4"; end
            else if (a == 'h11) begin mdl[a] = d | FOM; ew = 1'b0; rq = "R5"; end
            else if (a == 'h10) begin er = 1'b1; ew = 1'b0; rq = "R6"; end
            else if (a == 'h38) begin ew = (d != 0); rq = "R7"; end
        end
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk(warn == ew, rq, 32'(warn), 32'(ew));
        chk(redirect_valid == er && rd_valid == 1'b0, rq,
            32'(redirect_valid), 32'(er));
        if (er) chk(redirect_pc == d, "R6", redirect_pc, d);
    endtask

    task automatic do_rd(int a);
        bit p = sm || sumra;
        bit ok = p && a < NSPR && readable(a);
        logic [31:0] pp = 32'hB000_0000 | 32'(a);
        logic [31:0] ed = ok ? ((a == 'h12) ? pp : mdl[a]) : 32'h0;
        string rq = !p ? "R1" : (a >= NSPR) ? "R2" :
                    (a >= SB && a < SB + SN) ? "R9" : ok ? "R3" : "R3";
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a); prev_pc = pp;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rd_valid == 1'b1, "R8", 32'(rd_valid), 32'h1);
        chk(rd_data == ed, rq, rd_data, ed);
        chk(warn == !ok, rq, 32'(warn), 32'(!ok));
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #500000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
        summary();
    end

    initial begin
        for (int i = 0; i < 256; i++) mdl[i] = '0;
        mdl['h00] = VERV; mdl['h01] = UNV; mdl['h02] = CFGV; mdl['h11] = SRR;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state of all response outputs
        chk(!rd_valid && !warn && !redirect_valid, "R8",
            {29'b0, rd_valid, warn, redirect_valid}, 32'h0);
        sm = 1'b1;
        do_rd('h11);   // R5 reset value of status
        do_rd('h14);
        // R4 R5 R6 R7 R10 R2: privileged write sweep
        for (int a = 0; a < 256; a++) do_wr(a, {8'hC3, 8'(a), ~8'(a), 8'(a)});
        // R3 R9: privileged read sweep
        for (int a = 0; a < 256; a++) do_rd(a);
        // R8: idle cycle gives no response
        @(negedge clk);
        chk(!rd_valid && !warn && !redirect_valid, "R8",
            {29'b0, rd_valid, warn, redirect_valid}, 32'h0);
        // R1: fully unprivileged writes and reads refused
        sm = 1'b0; sumra = 1'b0;
        for (int a = 0; a < 256; a++) do_wr(a, ~{8'hC3, 8'(a), ~8'(a), 8'(a)});
        for (int a = 0; a < 256; a += 3) do_rd(a);
        // R1: contents unchanged after refused writes
        sm = 1'b1;
        for (int a = 0; a < 256; a++) do_rd(a);
        // R1: user access permitted through sumra
        sm = 1'b0; sumra = 1'b1;
        for (int a = 0; a < 256; a++) do_wr(a, {8'h5A, 8'(a), 8'(a), ~8'(a)});
        for (int a = 0; a < 256; a++) do_rd(a);
        // R7: zero timer-mode write accepted silently
        do_wr('h38, 32'h0);
        // R5: status written with forced bit clear reads back with it set
        do_wr('h11, 32'h0000_0000);
        do_rd('h11);
        // R6: redirect to a second target
        do_wr('h10, 32'hDEAD_BEE0);
        summary();
    end

endmodule